// File: doc/BRIEF.md
# Relative Branch Target Unit

This block produces the next program counter for a 16-bit instruction stream in which every instruction is one 16-bit word. Each step the decoder supplies three things: a branch kind, the raw offset field of the instruction, and a condition selector. It also presents the current carry and zero flags. From these the unit works out whether the branch is taken and where execution goes next.

A conditional branch carries a 9-bit signed offset counted in words. The unconditional branch carries a 10-bit signed word offset. The target is formed from the address of the following instruction plus the doubled offset. Every other instruction simply moves on by one word.

The target logic is combinational. A program counter register holds the current address. It loads the computed value on each cycle where the step enable is high, and it returns to a parameterized start address on reset. The reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `brt_branch_unit`

## Requirements
- R1: While reset is asserted, and afterwards until the first step, `pc_q` equals the start address (default 16'h4000).
- R2: With kind 2'b00 (sequential) or 2'b11 (reserved), `taken` is 0 and `next_pc` is `pc_q + 2`, whatever the offset, selector and flags are.
- R3: With kind 2'b01 and `cond_sel` 0 (carry clear), `taken` is 1 exactly when `flag_c` is 0. `flag_z` has no effect.
- R4: With kind 2'b01 and `cond_sel` 1 (equal), `taken` is 1 exactly when `flag_z` is 1. `flag_c` has no effect.
- R5: A taken conditional branch gives `next_pc = pc_q + 2 + (sext(offset_field[8:0]) << 1)`. `offset_field[9]` is ignored.
- R6: With kind 2'b10 (unconditional), `taken` is always 1 and `next_pc = pc_q + 2 + (sext(offset_field[9:0]) << 1)`. The flags have no effect.
- R7: A conditional branch that is not taken gives `next_pc = pc_q + 2`.
- R8: All address arithmetic wraps modulo 2^16, both forwards past 16'hFFFE and backwards below 16'h0000.
- R9: Bit 0 of `next_pc` is always 0.
- R10: On a rising clock edge with `step_en` high, `pc_q` takes the value `next_pc` had before the edge. With `step_en` low, `pc_q` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Load `next_pc` into the program counter |
| kind | input | 2 | Branch kind: 00 sequential, 01 conditional, 10 unconditional, 11 reserved |
| offset_field | input | 10 | Signed word offset field of the instruction |
| cond_sel | input | 1 | Condition: 0 carry clear, 1 equal |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| pc_q | output | 16 | Current program counter |
| next_pc | output | 16 | Computed next program counter |
| taken | output | 1 | Branch taken indication |

## Verification
The bench covers the offset extremes for both widths. It uses +511/−512 words for the unconditional branch, and −256 words plus a field with bit 9 set for the conditional form. A unit that sign-extended from the wrong bit, or let bit 9 leak into a conditional offset, would land hundreds of bytes off.

The bench swaps each flag that a condition does not use. This exposes a condition wired to the wrong flag or with the wrong polarity. Every row also checks the +2 base, which catches a target computed from the current instruction's own address.

Long chains of forward and backward jumps cross the 16-bit boundary. They reveal arithmetic that saturates or widens instead of wrapping. A final test holds the step enable low to show that the register does not drift.

// File: rtl/brt_pkg.sv
package brt_pkg;

  typedef enum logic [1:0] {
    BK_SEQ    = 2'b00,
    BK_COND   = 2'b01,
    BK_ALWAYS = 2'b10,
    BK_RSVD   = 2'b11
  } br_kind_e;

  typedef enum logic {
    CS_CARRY_CLR = 1'b0,
    CS_EQUAL     = 1'b1
  } cond_sel_e;

  typedef struct packed {
    logic c;
    logic z;
  } flags_t;

endpackage

// File: rtl/brt_rst_sync.sv
module brt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/brt_offset_ext.sv
module brt_offset_ext #(
  parameter int IN_W  = 9,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  off_words,
  output logic [OUT_W-1:0] off_bytes
);

  localparam int PAD_W = OUT_W - IN_W - 1;

  generate
    if (PAD_W > 0) begin : g_extend
      always_comb begin
        off_bytes = {{PAD_W{off_words[IN_W-1]}}, off_words, 1'b0};
      end
    end else begin : g_trunc
      always_comb begin
        off_bytes = {off_words[OUT_W-2:0], 1'b0};
      end
    end
  endgenerate

endmodule

// File: rtl/brt_cond_eval.sv
module brt_cond_eval
  import brt_pkg::*;
(
  input  br_kind_e  kind,
  input  cond_sel_e cond_sel,
  input  flags_t    flags,
  output logic      taken,
  output logic      use_long
);

  logic cond_true;

  always_comb begin
    unique case (cond_sel)
      CS_CARRY_CLR: cond_true = ~flags.c;
      CS_EQUAL:     cond_true = flags.z;
      default:      cond_true = 1'b0;
    endcase
  end

  always_comb begin
    taken    = 1'b0;
    use_long = 1'b0;
    unique case (kind)
      BK_COND:   taken = cond_true;
      BK_ALWAYS: begin
        taken    = 1'b1;
        use_long = 1'b1;
      end
      default: begin
        taken    = 1'b0;
        use_long = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/brt_target_calc.sv
module brt_target_calc #(
  parameter int PC_W = 16
) (
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] short_off,
  input  logic [PC_W-1:0] long_off,
  input  logic            taken,
  input  logic            use_long,
  output logic [PC_W-1:0] next_pc
);

  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(2);

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] sel_off;
  logic [PC_W-1:0] tgt_pc;
  logic [PC_W-1:0] raw_pc;

  always_comb begin
    seq_pc  = pc + INSN_BYTES;
    sel_off = use_long ? long_off : short_off;
    tgt_pc  = seq_pc + sel_off;
    raw_pc  = taken ? tgt_pc : seq_pc;
    next_pc = {raw_pc[PC_W-1:1], 1'b0};
  end

endmodule

// File: rtl/brt_pc_reg.sv
module brt_pc_reg #(
  parameter int              PC_W       = 16,
  parameter logic [PC_W-1:0] START_ADDR = 16'h4000
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            en,
  input  logic [PC_W-1:0] d,
  output logic [PC_W-1:0] q
);

  localparam logic [PC_W-1:0] RST_VAL = {START_ADDR[PC_W-1:1], 1'b0};

  logic [PC_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= RST_VAL;
    else         q <= q_nxt;
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!arst_n)
    !en |=> (q == $past(q)));

  p_load_r10: assert property (@(posedge clk) disable iff (!arst_n)
    en |=> (q == $past(d)));

endmodule

// File: rtl/brt_branch_unit.sv
module brt_branch_unit
  import brt_pkg::*;
#(
  parameter int              PC_W       = 16,
  parameter int              COND_OFF_W = 9,
  parameter int              JUMP_OFF_W = 10,
  parameter logic [PC_W-1:0] START_ADDR = 16'h4000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step_en,
  input  logic [1:0]            kind,
  input  logic [JUMP_OFF_W-1:0] offset_field,
  input  logic                  cond_sel,
  input  logic                  flag_c,
  input  logic                  flag_z,
  output logic [PC_W-1:0]       pc_q,
  output logic [PC_W-1:0]       next_pc,
  output logic                  taken
);

  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  logic            srst_n;
  br_kind_e        kind_e;
  cond_sel_e       sel_e;
  flags_t          flags;
  logic            use_long;
  logic [PC_W-1:0] short_off;
  logic [PC_W-1:0] long_off;

  always_comb begin
    kind_e  = br_kind_e'(kind);
    sel_e   = cond_sel_e'(cond_sel);
    flags.c = flag_c;
    flags.z = flag_z;
  end

  brt_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (srst_n)
  );

  brt_offset_ext #(.IN_W(COND_OFF_W), .OUT_W(PC_W)) u_ext_cond (
    .off_words (offset_field[COND_OFF_W-1:0]),
    .off_bytes (short_off)
  );

  brt_offset_ext #(.IN_W(JUMP_OFF_W), .OUT_W(PC_W)) u_ext_jump (
    .off_words (offset_field),
    .off_bytes (long_off)
  );

  brt_cond_eval u_cond (
    .kind     (kind_e),
    .cond_sel (sel_e),
    .flags    (flags),
    .taken    (taken),
    .use_long (use_long)
  );

  brt_target_calc #(.PC_W(PC_W)) u_calc (
    .pc        (pc_q),
    .short_off (short_off),
    .long_off  (long_off),
    .taken     (taken),
    .use_long  (use_long),
    .next_pc   (next_pc)
  );

  brt_pc_reg #(.PC_W(PC_W), .START_ADDR(START_ADDR)) u_pc (
    .clk    (clk),
    .arst_n (srst_n),
    .en     (step_en),
    .d      (next_pc),
    .q      (pc_q)
  );

  p_seq_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (kind == 2'b00 || kind == 2'b11) |-> (!taken && next_pc == pc_q + STEP));

  p_carry_clr_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (kind == 2'b01 && !cond_sel) |-> (taken == !flag_c));

  p_equal_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (kind == 2'b01 && cond_sel) |-> (taken == flag_z));

  p_jump_taken_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (kind == 2'b10) |-> taken);

  p_fallthru_r7: assert property (@(posedge clk) disable iff (!srst_n)
    !taken |-> (next_pc == pc_q + STEP));

  p_even_r9: assert property (@(posedge clk) disable iff (!srst_n)
    next_pc[0] == 1'b0);

endmodule

// File: tb/brt_branch_unit_test.sv
module brt_branch_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] START = 16'h4000;
  localparam int NVEC = 14;

  // {kind[2], offset[10], cond_sel, c, z, exp_taken, exp_disp[16]} = 32 bits
  localparam logic [31:0] VEC [0:NVEC-1] = '{
    {2'b00, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0002},  // R2 seq
    {2'b01, 10'h005, 1'b0, 1'b0, 1'b1, 1'b1, 16'h000C},  // R3 C=0 taken
    {2'b01, 10'h005, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0002},  // R3/R7 C=1
    {2'b01, 10'h1FF, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000},  // R4 Z=1, -1 word
    {2'b01, 10'h1FF, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0002},  // R4/R7 Z=0
    {2'b01, 10'h100, 1'b1, 1'b0, 1'b1, 1'b1, 16'hFE02},  // R5 -256 words
    {2'b01, 10'h2FF, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0200},  // R5 bit9 ignored
    {2'b01, 10'h0FF, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0200},  // R5 +255 words
    {2'b01, 10'h005, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0002},  // R4 C irrelevant
    {2'b10, 10'h1FF, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0400},  // R6 +511
    {2'b10, 10'h200, 1'b1, 1'b0, 1'b1, 1'b1, 16'hFC02},  // R6 -512
    {2'b10, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000},  // R6 -1
    {2'b11, 10'h123, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0002},  // R2 reserved
    {2'b00, 10'h3FF, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0002}   // R2 offset ignored
  };

  logic        clk;
  logic        rst_n;
  logic        step_en;
  logic [1:0]  kind;
  logic [9:0]  offset_field;
  logic        cond_sel;
  logic        flag_c;
  logic        flag_z;
  logic [15:0] pc_q;
  logic [15:0] next_pc;
  logic        taken;

  int checks;
  int errors;
  logic [15:0] pc_m;
  bit done;

  brt_branch_unit uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_en      (step_en),
    .kind         (kind),
    .offset_field (offset_field),
    .cond_sel     (cond_sel),
    .flag_c       (flag_c),
    .flag_z       (flag_z),
    .pc_q         (pc_q),
    .next_pc      (next_pc),
    .taken        (taken)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] k, input logic [9:0] off,
                       input logic cs, input logic c, input logic z);
    @(negedge clk);
    step_en = 1'b0;
    kind = k; offset_field = off; cond_sel = cs; flag_c = c; flag_z = z;
    #1;
  endtask

  task automatic step_and_check(input string req);
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    pc_m = pc_m + 16'h0000;
    chk16(req, pc_q, pc_m);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] exp_next;
    logic        wrapped;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; step_en = 1'b0; kind = 2'b00; offset_field = '0;
    cond_sel = 1'b0; flag_c = 1'b0; flag_z = 1'b0;
    #(CLK_PERIOD * 3 + 2);
    chk16("R1 in reset", pc_q, START);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk16("R1 after release", pc_q, START);
    pc_m = START;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] v;
      v = VEC[i];
      drive(v[31:30], v[29:20], v[19], v[18], v[17]);
      exp_next = pc_m + v[15:0];
      chk1($sformatf("R2/R3/R4/R6 taken vec%0d", i), taken, v[16]);
      chk16($sformatf("R5/R6/R7 next_pc vec%0d", i), next_pc, exp_next);
      chk1($sformatf("R9 even vec%0d", i), next_pc[0], 1'b0);
      pc_m = exp_next;
      step_and_check($sformatf("R10 load vec%0d", i));
    end

    // R10: hold with step_en low
    drive(2'b10, 10'h010, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk16("R10 hold", pc_q, pc_m);

    // R8: forward wrap, +1024 per step
    wrapped = 1'b0;
    for (int i = 0; i < 64; i++) begin
      drive(2'b10, 10'h1FF, 1'b0, 1'b0, 1'b0);
      exp_next = pc_m + 16'h0400;
      if (exp_next < pc_m) begin
        wrapped = 1'b1;
        chk16("R8 forward wrap", next_pc, exp_next);
      end
      pc_m = exp_next;
      step_en = 1'b1;
      @(negedge clk);
      step_en = 1'b0;
    end
    chk16("R8 after forward laps", pc_q, pc_m);
    chk1("R8 forward wrap seen", wrapped, 1'b1);

    // R8: backward wrap, -1022 per step
    wrapped = 1'b0;
    for (int i = 0; i < 70; i++) begin
      drive(2'b10, 10'h200, 1'b0, 1'b0, 1'b0);
      exp_next = pc_m + 16'hFC02;
      if (exp_next > pc_m) begin
        wrapped = 1'b1;
        chk16("R8 backward wrap", next_pc, exp_next);
      end
      pc_m = exp_next;
      step_en = 1'b1;
      @(negedge clk);
      step_en = 1'b0;
    end
    chk16("R8 after backward laps", pc_q, pc_m);
    chk1("R8 backward wrap seen", wrapped, 1'b1);

    // R1: reset mid-run
    drive(2'b00, 10'h000, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b0;
    #1;
    chk16("R1 async reset", pc_q, START);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk16("R1 held after release", pc_q, START);
    chk16("R2 next after reset", next_pc, START + 16'h0002);

    finish_run();
  end

endmodule